// File: doc/BRIEF.md
# Serial Configuration Bitstream Store

This block holds a configuration bitstream and hands it out one bit per rising edge of a configuration clock, the way a serial boot memory feeds an FPGA that loads itself. The FPGA (or another clock source) drives the clock. The block keeps an internal bit address. Each enabled edge moves that address forward by one, and the bit at the new address shows up on the serial output within the same clock period, so the loader can sample it on a later edge.

Two pins gate the read. An active-low chip enable selects the device, and a combined control pin does two jobs: it clears the address and it floats the output. The active level of the control pin is chosen by a polarity input. With the active-low choice, the control pin can share a pulled-up open-drain line with the loader. The tri-state data pin is modelled as a data bit plus an output enable. When the chip is deselected, the block reports standby. A word-wide write port fills the bit array before any read takes place. The address stops at the last stored bit and keeps driving that bit, and a flag shows when the end has been reached.

Top module: `bitstream_store`

## Requirements
- R1: On each rising `clk` edge where `ce_n` is low and the reset function is inactive, the bit address goes up by exactly one, and `dout` shows the bit at the new address before the next edge.
- R2: While the reset function is active, the address is held at zero and `dout_oe` is low. Once the reset function is released, the read restarts at bit 0.
- R3: The reset function is active when `cfg_ctl` equals 1 if the captured polarity is 0, and when `cfg_ctl` equals 0 if the captured polarity is 1. `ctl_act_low` is captured only on edges where `rst` is high, `ce_n` is high or the reset function is active. A change of `ctl_act_low` during a read has no effect.
- R4: While `ce_n` is high, `dout_oe` is low and `standby` is high with no clock needed, and the next edge clears the address.
- R5: `standby` stays high after `ce_n` falls until the first rising edge with `ce_n` low, and goes low after that edge.
- R6: `dout_oe` is high exactly when `ce_n` is low and the reset function is inactive, and it follows those inputs combinationally.
- R7: Bit address a maps to word a/WORD_W at bit position WORD_W-1-(a mod WORD_W), so each word is sent MSB first.
- R8: When the address reaches DEPTH_BITS-1, further enabled edges leave it there and `dout` keeps the last bit. `at_end` is high while the address equals DEPTH_BITS-1.
- R9: A write (`wr_en` high) stores `wr_data` at word `wr_addr` on the edge, unless a read is enabled (`ce_n` low and the reset function inactive) on that edge, in which case the write is ignored.
- R10: Synchronous `rst` clears the address, sets `standby` high and captures `ctl_act_low`. While `rst` is high, `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high system reset |
| ce_n | input | 1 | Chip enable, active low |
| cfg_ctl | input | 1 | Combined reset / output-enable pin |
| ctl_act_low | input | 1 | Polarity: 1 makes `cfg_ctl` low mean reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | WAW | Word address for the write |
| wr_data | input | WORD_W | Word to store |
| dout | output | 1 | Serial bitstream bit |
| dout_oe | output | 1 | Drive enable for the serial pin (low = floating) |
| standby | output | 1 | Low-power standby indication |
| at_end | output | 1 | Address sits on the last stored bit |

## Verification
The bench builds the block with WORD_W = 8 and DEPTH_BITS = 100. That gives 13 words, and the last word is only half used. A run of about a hundred edges is enough to walk the whole store, to reach the final bit at an offset inside a word, and to push past it so the saturation can be seen. Because the store is small, one test can fill every word, stream it end to end under both polarities, and confirm that words written during standby appear while a word written during a read does not.

// File: rtl/bss_pkg.sv
package bss_pkg;

  // Operating state of the serial read path.
  typedef enum logic [1:0] {
    BS_STANDBY = 2'd0,
    BS_HELD    = 2'd1,
    BS_READ    = 2'd2
  } bs_mode_e;

endpackage

// File: rtl/bss_ctl.sv
module bss_ctl
  import bss_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ce_n,
  input  logic     cfg_ctl,
  input  logic     ctl_act_low,
  output logic     hold,
  output logic     adv,
  output logic     standby,
  output bs_mode_e mode
);

  logic pol_q;
  logic stby_q;
  logic rst_act;

  // Reset function level depends on captured polarity.
  assign rst_act = cfg_ctl ^ pol_q;

  always_comb begin
    if (ce_n)         mode = BS_STANDBY;
    else if (rst_act) mode = BS_HELD;
    else              mode = BS_READ;
  end

  assign hold    = rst || (mode != BS_READ);
  assign adv     = (mode == BS_READ);
  assign standby = ce_n | stby_q;

  // Polarity is only taken while no read is under way.
  always_ff @(posedge clk) begin
    if (rst || ce_n || rst_act) pol_q <= ctl_act_low;
  end

  always_ff @(posedge clk) begin
    if (rst) stby_q <= 1'b1;
    else     stby_q <= ce_n;
  end

  // R3: polarity frozen across an active read edge
  p_pol_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == BS_READ) |=> (pol_q == $past(pol_q)));

  // R5: standby drops after the first selected edge
  p_stby_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !ce_n |=> (standby == ce_n));

endmodule

// File: rtl/bss_addr.sv
module bss_addr #(
  parameter int DEPTH_BITS = 1020,
  localparam int AW = (DEPTH_BITS > 2) ? $clog2(DEPTH_BITS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          adv,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] next_addr,
  output logic          at_end
);

  localparam logic [AW-1:0] LAST_A = AW'(DEPTH_BITS - 1);

  always_comb begin
    if (hold)                        next_addr = '0;
    else if (adv && addr_q != LAST_A) next_addr = addr_q + 1'b1;
    else                             next_addr = addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= next_addr;
  end

  assign at_end = (addr_q == LAST_A);

  // R2: a held cycle leaves the address at zero
  p_held_zero_r2: assert property (@(posedge clk) disable iff (rst)
    hold |=> (addr_q == '0));

  // R1: one step per enabled edge below the end
  p_step_one_r1: assert property (@(posedge clk) disable iff (rst)
    (adv && !hold && !at_end) |=> (addr_q == $past(addr_q) + 1'b1));

  // R8: the end position is sticky while reading
  p_end_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && !hold && at_end) |=> at_end);

endmodule

// File: rtl/bss_mem.sv
module bss_mem #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 128,
  localparam int WAW = (NUM_WORDS > 2) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_block,
  input  logic [WAW-1:0]    wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WAW-1:0]    rd_idx,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] mem [NUM_WORDS];

  // Simple dual-port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en && !wr_block && (int'(wr_idx) < NUM_WORDS)) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_word <= mem[rd_idx];
  end

endmodule

// File: rtl/bitstream_store.sv
module bitstream_store
  import bss_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int DEPTH_BITS = 1020,
  localparam int NUM_WORDS = (DEPTH_BITS + WORD_W - 1) / WORD_W,
  localparam int WAW       = (NUM_WORDS > 2) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              cfg_ctl,
  input  logic              ctl_act_low,
  input  logic              wr_en,
  input  logic [WAW-1:0]    wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              standby,
  output logic              at_end
);

  localparam int AW = (DEPTH_BITS > 2) ? $clog2(DEPTH_BITS) : 1;
  localparam int OW = $clog2(WORD_W);

  logic              hold;
  logic              adv;
  bs_mode_e          mode;
  logic [AW-1:0]     addr_q;
  logic [AW-1:0]     next_addr;
  logic [WORD_W-1:0] rd_word;
  logic [OW-1:0]     bit_off;
  logic [WAW-1:0]    rd_idx;

  bss_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .ce_n        (ce_n),
    .cfg_ctl     (cfg_ctl),
    .ctl_act_low (ctl_act_low),
    .hold        (hold),
    .adv         (adv),
    .standby     (standby),
    .mode        (mode)
  );

  bss_addr #(.DEPTH_BITS(DEPTH_BITS)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .adv       (adv),
    .addr_q    (addr_q),
    .next_addr (next_addr),
    .at_end    (at_end)
  );

  // Look one address ahead so the word is ready with the address.
  assign rd_idx = WAW'(next_addr >> OW);

  bss_mem #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_mem (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_block (adv),
    .wr_idx   (wr_addr),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_word  (rd_word)
  );

  // MSB first within each word.
  assign bit_off = addr_q[OW-1:0];
  assign dout    = rd_word[OW'(WORD_W - 1) - bit_off];
  assign dout_oe = (mode == BS_READ) && !rst;

  // R4: deselect floats the pin and shows standby
  p_desel_float_r4: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> (!dout_oe && standby));

  // R6: driving implies selected
  p_drive_sel_r6: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> !ce_n);

endmodule

// File: tb/test_bitstream_store.sv
module test_bitstream_store;
  localparam int WORD_W     = 8;
  localparam int DEPTH_BITS = 100;
  localparam int NUM_WORDS  = (DEPTH_BITS + WORD_W - 1) / WORD_W;
  localparam int WAW        = (NUM_WORDS > 2) ? $clog2(NUM_WORDS) : 1;
  localparam int LAST       = DEPTH_BITS - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst, ce_n, cfg_ctl, ctl_act_low, wr_en;
  logic [WAW-1:0]    wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic              dout, dout_oe, standby, at_end;

  bitstream_store #(.WORD_W(WORD_W), .DEPTH_BITS(DEPTH_BITS)) i_bitstream_store (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cfg_ctl(cfg_ctl), .ctl_act_low(ctl_act_low),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout), .dout_oe(dout_oe), .standby(standby), .at_end(at_end)
  );

  logic [WORD_W-1:0] img [NUM_WORDS];
  int checks = 0;
  int errors = 0;
  int model_a = 0;
  logic exp_q[$];

  function automatic logic exp_bit(int a);
    return img[a / WORD_W][WORD_W - 1 - (a % WORD_W)];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Driver: every enabled edge pushes the bit the loader should see.
  task automatic read_edges(int n);
    for (int i = 0; i < n; i++) begin
      tick();
      if (model_a < LAST) model_a++;
      exp_q.push_back(exp_bit(model_a));
    end
  endtask

  // Monitor: compare mid-cycle.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic e;
      e = exp_q.pop_front();
      chk("R1 R7 stream drive", {31'd0, dout_oe}, 32'd1);
      chk("R1 R7 stream bit", {31'd0, dout}, {31'd0, e});
    end
  end

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    for (int w = 0; w < NUM_WORDS; w++) img[w] = WORD_W'((w * 59) ^ 198);
    rst = 1'b1; ce_n = 1'b1; cfg_ctl = 1'b0; ctl_act_low = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) tick();
    chk("R10 oe in reset", {31'd0, dout_oe}, 32'd0);
    chk("R10 standby in reset", {31'd0, standby}, 32'd1);
    chk("R10 at_end in reset", {31'd0, at_end}, 32'd0);
    rst = 1'b0;

    // Fill while deselected (R9).
    for (int w = 0; w < NUM_WORDS; w++) begin
      wr_en = 1'b1; wr_addr = WAW'(w); wr_data = img[w];
      tick();
    end
    wr_en = 1'b0;
    chk("R4 float when deselected", {31'd0, dout_oe}, 32'd0);

    // Select with reset function active (active-high polarity).
    cfg_ctl = 1'b1; ce_n = 1'b0; #1;
    chk("R5 standby before edge", {31'd0, standby}, 32'd1);
    chk("R2 float while held", {31'd0, dout_oe}, 32'd0);
    tick();
    chk("R5 standby after edge", {31'd0, standby}, 32'd0);
    tick();
    chk("R2 at_end low while held", {31'd0, at_end}, 32'd0);

    cfg_ctl = 1'b0; #1;
    chk("R6 drive on release", {31'd0, dout_oe}, 32'd1);
    model_a = 0;
    chk("R7 first bit", {31'd0, dout}, {31'd0, exp_bit(0)});
    read_edges(30);

    // Write attempt during an enabled edge is dropped (R9).
    wr_en = 1'b1; wr_addr = '0; wr_data = ~img[0];
    read_edges(1);
    wr_en = 1'b0;

    // Polarity change mid-read has no effect (R3).
    ctl_act_low = 1'b1;
    read_edges(3);
    chk("R3 polarity ignored in read", {31'd0, dout_oe}, 32'd1);

    read_edges(LAST - model_a);
    chk("R8 end flag", {31'd0, at_end}, 32'd1);
    read_edges(4);
    chk("R8 end flag held", {31'd0, at_end}, 32'd1);
    chk("R8 last bit held", {31'd0, dout}, {31'd0, exp_bit(LAST)});
    @(negedge clk); #1;

    // Deselect: float, standby, counter clear, polarity taken (R4, R3).
    ce_n = 1'b1; #1;
    chk("R4 float on deselect", {31'd0, dout_oe}, 32'd0);
    chk("R4 standby on deselect", {31'd0, standby}, 32'd1);
    tick();
    chk("R4 counter cleared", {31'd0, at_end}, 32'd0);
    wr_en = 1'b1; wr_addr = WAW'(1); wr_data = 8'hA5; img[1] = 8'hA5;
    tick();
    wr_en = 1'b0;

    // Active-low polarity now: cfg_ctl low means reset.
    ce_n = 1'b0; #1;
    chk("R3 low level resets", {31'd0, dout_oe}, 32'd0);
    tick();
    cfg_ctl = 1'b1; #1;
    chk("R3 high level drives", {31'd0, dout_oe}, 32'd1);
    model_a = 0;
    chk("R9 word kept after blocked write", {31'd0, dout}, {31'd0, exp_bit(0)});
    read_edges(15);
    @(negedge clk); #1;

    cfg_ctl = 1'b0; #1;
    chk("R2 float on reset function", {31'd0, dout_oe}, 32'd0);
    tick();
    cfg_ctl = 1'b1; #1;
    model_a = 0;
    chk("R2 restart at bit 0", {31'd0, dout}, {31'd0, exp_bit(0)});
    read_edges(9);
    @(negedge clk); #1;
    finish_sim();
  end
endmodule